// File: doc/BRIEF.md
# Periodic Down-Counting Interval Timer

This block is a register-programmed interval timer built around a down-counter that is 32 bits wide by default. One of three tick-enable inputs is chosen by a field in the control word, or none is chosen, which stops the timer. The chosen tick passes through a programmable 12-bit divider. Each divided step moves the counter down by one. When the count leaves zero, it either reloads from the load register or wraps to all-ones. A match against the compare register sets a sticky flag, can raise an interrupt, and can drive an output pin that toggles, sets or clears.

Software uses a simple write/read register port. Writes are one-cycle strobes and are always accepted. Reads are combinational from the addressed register. The port has no back-pressure and no valid/ready pairing. It is a control path and not a data stream. Three request inputs (debug, wait, stop) freeze counting unless the control word allows counting in that state.

Top module: `tmr_interval`

## Requirements
- R1: After reset, the control register and status flag read 0, the compare register reads 0, the load register and counter read all-ones, and both `irq` and `tmr_out` are low.
- R2: Register addresses are control=0, status=1 (flag in bit 0), load=2, compare=3 and counter=4. The counter is read-only, and writes to it are ignored.
- R3: Control field bits [25:24] choose the tick. 00 stops the counter; 01, 10 and 11 choose `tick_src[0]`, `[1]` and `[2]`. Field bits [15:4] hold a value D, and the counter steps once per D+1 selected ticks. Counting also needs enable bit 0 set.
- R4: With reload bit 3 set, a step taken at count 0 loads the load-register value. The match period is therefore (load+1) steps.
- R5: With reload bit 3 clear, a step taken at count 0 wraps the counter to all-ones.
- R6: Enable-mode is control bit 1. If bit 1 is set when a write takes enable from 0 to 1, the counter restarts from the load register. If bit 1 is clear, the held count resumes. A disabled counter holds its value.
- R7: Overwrite is control bit 17. When bit 17 is set, a load-register write is copied into the counter on the same edge. When bit 17 is clear, the counter is left untouched.
- R8: A step taken while the counter equals the compare value sets the status flag on that edge. Writing 1 to status bit 0 clears the flag, and writing 0 has no effect. A match and a clear-write on the same edge leave the flag set. `irq` is high while the flag and interrupt-enable bit 2 are both set.
- R9: Pin mode is control bits [23:22]. On a match, 01 toggles `tmr_out`, 10 drives it low and 11 drives it high. Mode 00 holds it low.
- R10: A high `dbg_req`, `wait_req` or `stop_req` freezes counting unless the matching allow bit is set. The allow bits are bit 18 for debug, bit 19 for wait and bit 21 for stop.
- R11: Writing control bit 16 clears the control register except bits 18, 19 and 21. It also clears the flag and `tmr_out` and sets the counter to all-ones. Bit 16 reads back as 1 for one cycle and then clears itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| tick_src | input | 3 | Tick-enable inputs, one per selectable source |
| dbg_req | input | 1 | Debug-state request |
| wait_req | input | 1 | Wait-state request |
| stop_req | input | 1 | Stop-state request |
| irq | output | 1 | Compare interrupt |
| tmr_out | output | 1 | Compare-driven output pin |

## Verification
Two functions can land on the same edge: a counter step that matches the compare value, and a software write of 1 that clears the status flag. The bench provokes this by raising one tick pulse in the same cycle as the clear-write. It then judges the result by reading the flag: it must still be set, and the toggled pin must show the match was taken. The bench also measures random load and divider settings through the pin's toggle period, which must equal (D+1)·(load+1) clocks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W = 32;

  // control word bit positions (software decodes these)
  localparam int B_EN      = 0;
  localparam int B_ENMOD   = 1;
  localparam int B_OCIEN   = 2;
  localparam int B_RLD     = 3;
  localparam int B_PSC_LO  = 4;
  localparam int B_PSC_HI  = 15;
  localparam int B_SWR     = 16;
  localparam int B_IOVW    = 17;
  localparam int B_DBGEN   = 18;
  localparam int B_WAITEN  = 19;
  localparam int B_STOPEN  = 21;
  localparam int B_PIN_LO  = 22;
  localparam int B_PIN_HI  = 23;
  localparam int B_SRC_LO  = 24;
  localparam int B_SRC_HI  = 25;

  localparam int PSC_W = B_PSC_HI - B_PSC_LO + 1;
  localparam int SRC_W = B_SRC_HI - B_SRC_LO + 1;
  localparam int NUM_SRC = (1 << SRC_W) - 1;

  localparam logic [DATA_W-1:0] CTRL_WMASK = 32'h03EF_FFFF;
  localparam logic [DATA_W-1:0] CTRL_KEEP  = 32'h002C_0000;

  typedef enum logic [2:0] {
    RA_CTRL = 3'd0,
    RA_STAT = 3'd1,
    RA_LOAD = 3'd2,
    RA_CMP  = 3'd3,
    RA_CNT  = 3'd4
  } reg_addr_e;

  typedef enum logic [1:0] {
    PIN_OFF    = 2'd0,
    PIN_TOGGLE = 2'd1,
    PIN_CLEAR  = 2'd2,
    PIN_SET    = 2'd3
  } pin_mode_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  input  logic [DIV_W-1:0] div,
  output logic             step
);
  logic [DIV_W-1:0] phase_q;

  assign step = tick && (phase_q >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase_q <= '0;
    else if (clear)  phase_q <= '0;
    else if (step)   phase_q <= '0;
    else if (tick)   phase_q <= phase_q + 1'b1;
  end

  // a non-zero divider never yields steps on two adjacent edges
  p_step_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && div != '0) |=> (!step || div == '0));
endmodule

// File: rtl/tmr_downcount.sv
module tmr_downcount #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         load_now,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] reload_val,
  input  logic [W-1:0] cmp_val,
  input  logic         rld,
  output logic [W-1:0] count,
  output logic         match
);
  localparam logic [W-1:0] ALL_ONES = '1;

  logic [W-1:0] cnt_q;

  assign count = cnt_q;
  assign match = step && !load_now && (cnt_q == cmp_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= ALL_ONES;
    else if (load_now)  cnt_q <= load_val;
    else if (step) begin
      if (cnt_q == '0)  cnt_q <= rld ? reload_val : ALL_ONES;
      else              cnt_q <= cnt_q - 1'b1;
    end
  end

  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_now && rld && cnt_q == '0) |=> count == $past(reload_val));

  p_freerun_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_now && !rld && cnt_q == '0) |=> count == ALL_ONES);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load_now) |=> $stable(count));
endmodule

// File: rtl/tmr_interval.sv
module tmr_interval
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_SRC-1:0] tick_src,
  input  logic              dbg_req,
  input  logic              wait_req,
  input  logic              stop_req,
  output logic              irq,
  output logic              tmr_out
);
  localparam logic [CNT_W-1:0] CNT_ONES = '1;
  localparam int NUM_GATE = 3;

  logic [DATA_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  load_q, cmp_q, count;
  logic              flag_q, out_q;

  // register decode
  logic wr_ctrl, wr_stat, wr_load, wr_cmp;
  assign wr_ctrl = bus_wr && (bus_addr == RA_CTRL);
  assign wr_stat = bus_wr && (bus_addr == RA_STAT);
  assign wr_load = bus_wr && (bus_addr == RA_LOAD);
  assign wr_cmp  = bus_wr && (bus_addr == RA_CMP);

  logic swr_now, restart, overwrite, load_now;
  logic [CNT_W-1:0] load_val;
  assign swr_now   = wr_ctrl && bus_wdata[B_SWR];
  assign restart   = wr_ctrl && !bus_wdata[B_SWR] && bus_wdata[B_EN]
                     && !ctrl_q[B_EN] && bus_wdata[B_ENMOD];
  assign overwrite = wr_load && ctrl_q[B_IOVW];
  assign load_now  = swr_now || restart || overwrite;
  assign load_val  = swr_now ? CNT_ONES :
                     restart ? load_q   : bus_wdata[CNT_W-1:0];

  // tick source select: code 0 means stopped
  logic [NUM_SRC:0] src_vec;
  logic             src_tick;
  assign src_vec  = {tick_src, 1'b0};
  assign src_tick = src_vec[ctrl_q[B_SRC_HI:B_SRC_LO]];

  // low-power / debug gating, one gate per request
  logic [NUM_GATE-1:0] gate_req, gate_allow, gate_hit;
  assign gate_req   = {stop_req, wait_req, dbg_req};
  assign gate_allow = {ctrl_q[B_STOPEN], ctrl_q[B_WAITEN], ctrl_q[B_DBGEN]};
  for (genvar g = 0; g < NUM_GATE; g++) begin : g_gate
    assign gate_hit[g] = gate_req[g] && !gate_allow[g];
  end

  logic tick_ok, step, match;
  assign tick_ok = ctrl_q[B_EN] && src_tick && !(|gate_hit);

  tmr_prescale #(.DIV_W(PSC_W)) u_psc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (load_now),
    .tick  (tick_ok),
    .div   (ctrl_q[B_PSC_HI:B_PSC_LO]),
    .step  (step)
  );

  tmr_downcount #(.W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (step),
    .load_now   (load_now),
    .load_val   (load_val),
    .reload_val (load_q),
    .cmp_val    (cmp_q),
    .rld        (ctrl_q[B_RLD]),
    .count      (count),
    .match      (match)
  );

  // control register with self-clearing soft reset bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_ctrl) begin
      if (bus_wdata[B_SWR]) ctrl_q <= (ctrl_q & CTRL_KEEP) | (DATA_W'(1) << B_SWR);
      else                  ctrl_q <= bus_wdata & CTRL_WMASK;
    end else if (ctrl_q[B_SWR]) ctrl_q[B_SWR] <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= CNT_ONES;
      cmp_q  <= '0;
    end else begin
      if (wr_load) load_q <= bus_wdata[CNT_W-1:0];
      if (wr_cmp)  cmp_q  <= bus_wdata[CNT_W-1:0];
    end
  end

  // sticky flag: soft reset beats match, match beats clear-write
  logic flag_d;
  always_comb begin
    flag_d = flag_q;
    if (wr_stat && bus_wdata[0]) flag_d = 1'b0;
    if (match)                   flag_d = 1'b1;
    if (swr_now)                 flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  // output pin
  pin_mode_e pin_mode;
  assign pin_mode = pin_mode_e'(ctrl_q[B_PIN_HI:B_PIN_LO]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       out_q <= 1'b0;
    else if (swr_now) out_q <= 1'b0;
    else begin
      case (pin_mode)
        PIN_OFF:    out_q <= 1'b0;
        PIN_TOGGLE: if (match) out_q <= !out_q;
        PIN_CLEAR:  if (match) out_q <= 1'b0;
        PIN_SET:    if (match) out_q <= 1'b1;
        default:    out_q <= 1'b0;
      endcase
    end
  end

  assign tmr_out = out_q;
  assign irq     = flag_q && ctrl_q[B_OCIEN];

  always_comb begin
    case (bus_addr)
      RA_CTRL: bus_rdata = ctrl_q;
      RA_STAT: bus_rdata = DATA_W'(flag_q);
      RA_LOAD: bus_rdata = DATA_W'(load_q);
      RA_CMP:  bus_rdata = DATA_W'(cmp_q);
      RA_CNT:  bus_rdata = DATA_W'(count);
      default: bus_rdata = '0;
    endcase
  end

  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !swr_now) |=> flag_q);

  p_pin_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !swr_now && pin_mode == PIN_SET) |=> tmr_out);

  p_pin_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !swr_now && pin_mode == PIN_TOGGLE) |=> tmr_out != $past(tmr_out));

  p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req && !ctrl_q[B_DBGEN]) |-> !step);

  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> count == $past(load_q));

  p_overwrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overwrite |=> count == $past(bus_wdata[CNT_W-1:0]));

  p_soft_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    swr_now |=> (!flag_q && !tmr_out && count == CNT_ONES && ctrl_q[B_SWR]));
endmodule

// File: tb/test_tmr_interval.sv
module test_tmr_interval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  tick_src = 3'b000;
  logic        dbg_req = 1'b0, wait_req = 1'b0, stop_req = 1'b0;
  logic        irq, tmr_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_LOAD = 3'd2,
                         A_CMP = 3'd3, A_CNT = 3'd4;

  always #2 clk = ~clk;  // 250 MHz

  tmr_interval i_tmr_interval (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_src(tick_src),
    .dbg_req(dbg_req), .wait_req(wait_req), .stop_req(stop_req),
    .irq(irq), .tmr_out(tmr_out)
  );

  function automatic logic [31:0] ctl(input bit en, enm, oci, rld, input int psc,
                                      input bit iovw, dbg, wt, stp,
                                      input int pin, src);
    logic [31:0] c = '0;
    c[0] = en; c[1] = enm; c[2] = oci; c[3] = rld;
    c[15:4] = psc[11:0]; c[17] = iovw; c[18] = dbg; c[19] = wt; c[21] = stp;
    c[23:22] = pin[1:0]; c[25:24] = src[1:0];
    return c;
  endfunction

  function automatic int exp_period(input int load, input int div);
    return (div + 1) * (load + 1);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rdchk(input string req, input string what,
                       input logic [2:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(req, what, bus_rdata, exp);
  endtask

  task automatic pulse(input logic [2:0] m, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_src = m;
      @(negedge clk); tick_src = 3'b000;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20250);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdchk("R1", "ctrl", A_CTRL, 32'h0);
    rdchk("R1", "status", A_STAT, 32'h0);
    rdchk("R1", "load", A_LOAD, 32'hFFFF_FFFF);
    rdchk("R1", "counter", A_CNT, 32'hFFFF_FFFF);
    rdchk("R1", "compare", A_CMP, 32'h0);
    chk("R1", "irq", {31'b0, irq}, 32'h0);
    chk("R1", "pin", {31'b0, tmr_out}, 32'h0);

    // R2 map, counter read-only
    wr(A_CMP, 32'h0000_1234);
    rdchk("R2", "compare readback", A_CMP, 32'h0000_1234);
    wr(A_CNT, 32'h5);
    rdchk("R2", "counter write ignored", A_CNT, 32'hFFFF_FFFF);

    // R6 restart from load, R3 stepping on source 01
    wr(A_LOAD, 32'd100);
    rdchk("R7", "no overwrite by default", A_CNT, 32'hFFFF_FFFF);
    wr(A_CTRL, ctl(1,1,0,1,0,0,0,0,0,0,1));
    rdchk("R6", "restart from load", A_CNT, 32'd100);
    pulse(3'b001, 5);
    rdchk("R3", "five ticks", A_CNT, 32'd95);

    // R3 source 00 stops, source 10 picks tick_src[1]
    wr(A_CTRL, ctl(1,1,0,1,0,0,0,0,0,0,0));
    pulse(3'b111, 5);
    rdchk("R3", "source 00 stopped", A_CNT, 32'd95);
    wr(A_CTRL, ctl(1,1,0,1,0,0,0,0,0,0,2));
    pulse(3'b001, 3);
    rdchk("R3", "source 10 ignores tick0", A_CNT, 32'd95);
    pulse(3'b010, 3);
    rdchk("R3", "source 10 uses tick1", A_CNT, 32'd92);

    // R6 hold and resume
    wr(A_CTRL, ctl(0,0,0,1,0,0,0,0,0,0,1));
    pulse(3'b001, 3);
    rdchk("R6", "disabled holds", A_CNT, 32'd92);
    wr(A_CTRL, ctl(1,0,0,1,0,0,0,0,0,0,1));
    rdchk("R6", "resume keeps value", A_CNT, 32'd92);
    pulse(3'b001, 2);
    rdchk("R6", "resumed counting", A_CNT, 32'd90);
    wr(A_CTRL, ctl(0,0,0,1,0,0,0,0,0,0,1));
    wr(A_CTRL, ctl(1,1,0,1,0,0,0,0,0,0,1));
    rdchk("R6", "re-enable restarts", A_CNT, 32'd100);

    // R3 prescaler divide by 3
    wr(A_CTRL, ctl(0,0,0,1,0,0,0,0,0,0,1));
    wr(A_CTRL, ctl(1,1,0,1,2,0,0,0,0,0,1));
    pulse(3'b001, 6);
    rdchk("R3", "div3 after 6 ticks", A_CNT, 32'd98);
    pulse(3'b001, 2);
    rdchk("R3", "div3 partial", A_CNT, 32'd98);
    pulse(3'b001, 1);
    rdchk("R3", "div3 third", A_CNT, 32'd97);

    // R7 overwrite, R4 reload
    wr(A_CTRL, ctl(1,1,0,1,0,1,0,0,0,0,1));
    wr(A_LOAD, 32'd3);
    rdchk("R7", "overwrite on load write", A_CNT, 32'd3);
    pulse(3'b001, 3);
    rdchk("R4", "reached zero", A_CNT, 32'd0);
    pulse(3'b001, 1);
    rdchk("R4", "reload from zero", A_CNT, 32'd3);
    wr(A_CTRL, ctl(1,1,0,1,0,0,0,0,0,0,1));
    wr(A_LOAD, 32'd7);
    rdchk("R7", "no overwrite when clear", A_CNT, 32'd3);
    pulse(3'b001, 4);
    rdchk("R4", "reload takes new load", A_CNT, 32'd7);

    // R5 free run wrap
    wr(A_CTRL, ctl(1,1,0,0,0,0,0,0,0,0,1));
    pulse(3'b001, 8);
    rdchk("R5", "wrap to all-ones", A_CNT, 32'hFFFF_FFFF);

    // R8 compare flag and irq, R9 toggle
    wr(A_CTRL, ctl(1,1,1,1,0,1,0,0,0,1,1));
    wr(A_CMP, 32'd5);
    wr(A_STAT, 32'h1);
    wr(A_LOAD, 32'd6);
    pulse(3'b001, 1);
    rdchk("R8", "no match leaving 6", A_STAT, 32'h0);
    pulse(3'b001, 1);
    rdchk("R8", "match leaving 5", A_STAT, 32'h1);
    chk("R8", "irq raised", {31'b0, irq}, 32'h1);
    chk("R9", "toggle first match", {31'b0, tmr_out}, 32'h1);
    wr(A_STAT, 32'h0);
    rdchk("R8", "write 0 keeps flag", A_STAT, 32'h1);
    wr(A_STAT, 32'h1);
    rdchk("R8", "write 1 clears flag", A_STAT, 32'h0);
    chk("R8", "irq dropped", {31'b0, irq}, 32'h0);

    // R8 collision: match and clear-write on the same edge
    wr(A_LOAD, 32'd5);
    @(negedge clk);
    tick_src = 3'b001; bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 32'h1;
    @(negedge clk);
    tick_src = 3'b000; bus_wr = 1'b0;
    rdchk("R8", "match beats clear", A_STAT, 32'h1);
    chk("R9", "toggle second match", {31'b0, tmr_out}, 32'h0);

    // R9 set, clear, off
    wr(A_CTRL, ctl(1,1,1,1,0,1,0,0,0,3,1));
    wr(A_LOAD, 32'd5);
    pulse(3'b001, 1);
    chk("R9", "set mode", {31'b0, tmr_out}, 32'h1);
    wr(A_CTRL, ctl(1,1,1,1,0,1,0,0,0,2,1));
    wr(A_LOAD, 32'd5);
    pulse(3'b001, 1);
    chk("R9", "clear mode", {31'b0, tmr_out}, 32'h0);
    wr(A_CTRL, ctl(1,1,1,1,0,1,0,0,0,3,1));
    wr(A_LOAD, 32'd5);
    pulse(3'b001, 1);
    wr(A_CTRL, ctl(1,1,1,1,0,1,0,0,0,0,1));
    @(negedge clk);
    chk("R9", "off mode low", {31'b0, tmr_out}, 32'h0);

    // R10 gating
    dbg_req = 1'b1;
    wr(A_LOAD, 32'd20);
    pulse(3'b001, 3);
    rdchk("R10", "debug freezes", A_CNT, 32'd20);
    wr(A_CTRL, ctl(1,1,1,1,0,1,1,0,0,0,1));
    pulse(3'b001, 3);
    rdchk("R10", "debug allowed", A_CNT, 32'd17);
    dbg_req = 1'b0; wait_req = 1'b1;
    pulse(3'b001, 2);
    rdchk("R10", "wait freezes", A_CNT, 32'd17);
    wait_req = 1'b0; stop_req = 1'b1;
    pulse(3'b001, 1);
    rdchk("R10", "stop freezes", A_CNT, 32'd17);
    wr(A_CTRL, ctl(1,1,1,1,0,1,1,0,1,0,1));
    pulse(3'b001, 1);
    rdchk("R10", "stop allowed", A_CNT, 32'd16);
    stop_req = 1'b0;

    // R11 soft reset
    wr(A_CTRL, ctl(1,1,1,1,0,1,1,0,1,3,1));
    wr(A_LOAD, 32'd5);
    pulse(3'b001, 1);
    rdchk("R11", "flag set before reset", A_STAT, 32'h1);
    wr(A_CTRL, ctl(1,1,1,1,0,1,1,0,1,3,1) | 32'h0001_0000);
    rdchk("R11", "flag cleared", A_STAT, 32'h0);
    chk("R11", "pin cleared", {31'b0, tmr_out}, 32'h0);
    rdchk("R11", "counter all-ones", A_CNT, 32'hFFFF_FFFF);
    @(negedge clk);
    rdchk("R11", "ctrl keeps gating enables", A_CTRL, 32'h0024_0000);

    // random load and divider: toggle period
    for (int t = 0; t < 10; t++) begin
      int ld, dv, n;
      logic prev;
      ld = 2 + int'($urandom % 15);
      dv = int'($urandom % 4);
      tick_src = 3'b000;
      wr(A_CTRL, 32'h0);
      wr(A_LOAD, ld);
      wr(A_CMP, 32'h0);
      wr(A_CTRL, ctl(1,1,0,1,dv,0,0,0,0,1,1));
      @(negedge clk);
      tick_src = 3'b111;
      prev = tmr_out; n = 0;
      while (tmr_out == prev && n < 300) begin @(negedge clk); n++; end
      prev = tmr_out; n = 0;
      while (tmr_out == prev && n < 300) begin @(negedge clk); n++; end
      chk("R4", "toggle period", n, exp_period(ld, dv));
      tick_src = 3'b000;
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule